// File: doc/BRIEF.md
# NOR Flash Sector Erase Sequencer

This block runs a multi-sector erase on an 8-bit NOR flash that uses the classic unlock-cycle command set. A caller gives it a start byte address and a byte length. The block checks that both are whole sectors and that the range fits inside the device. It then sends the six-write erase unlock sequence and issues one sector-erase command per sector, lowest sector first. Between sector commands it reads status to confirm that the device's command-acceptance timer has not closed. When all commands are in, it polls status until the erase completes or is classified as failed. It reports a one-cycle `done` with a result code.

The flash side is a simple strobe bus. A write or read strobe, together with its address and data, stays asserted until the cycle in which `fl_rdy_i` is high. The access completes on that clock edge, and read data is taken on the same edge. A gap counter measures, in clock cycles, the time since the last sector command. If the device stalls the bus long enough that the acceptance window (`WINDOW_CYC`) closes, the erase is stopped with a window error. An optional poll limit (`POLL_LIMIT`, 0 disables it) bounds the completion polling.

States: `S_IDLE` (waiting for start) goes to `S_SETUP` on a valid request or to `S_FINISH` on an invalid one. `S_SETUP` runs the six unlock writes and then goes to `S_SECT`, which writes one sector command. After the first command the block goes straight to the next `S_SECT`; after any later command it goes through `S_TMR_RD` → `S_TMR_CHK` and then either back to `S_SECT` or on to polling. Polling loops `S_POLL_RD` → `S_POLL_CHK` until the erase completes (`S_FINISH`) or fails. Any error after the first bus write passes through `S_ABORT`, which writes a reset command, and then goes to `S_FINISH`. `S_FINISH` always returns to `S_IDLE`.

Top module: `nor_sector_eraser`

## Requirements
- R1: A request is rejected with code 1, and with no bus access, when any of these holds: the length is zero, the start address is not a multiple of the sector size, the length is not a multiple of the sector size, or start plus length exceeds the device size. A request that ends exactly at the device's last byte is accepted.
- R2: An accepted request first writes six commands, in this order: data F0 at address 555, AA at 555, 55 at 2AA, 80 at 555, AA at 555, 55 at 2AA (all hex).
- R3: After the unlock sequence, data 30 (hex) is written once to the base address of each requested sector, in ascending address order.
- R4: After every sector command except the first, status is read. If bit 3 of that status is 1, the erase stops with code 3.
- R5: A counter restarts when each non-final sector command is accepted. If it reaches `WINDOW_CYC` cycles before the next sector command is accepted, the erase stops with code 2.
- R6: During polling, a status read with bit 7 set ends the erase with code 0.
- R7: During polling, if two successive status reads are equal and bit 7 is clear, the erase has failed. The code is 4 when bit 5 of those reads is 1, and 5 otherwise.
- R8: When `POLL_LIMIT` is non-zero and that many poll reads have completed without a result, the erase stops with code 6.
- R9: A bus strobe, with its address and write data, stays asserted and unchanged until a cycle in which `fl_rdy_i` is high.
- R10: Every error raised after the first bus write is followed by one write of data F0 at address 555 before `done`.
- R11: `done_o` is a one-cycle pulse, in the same cycle that `busy_o` falls. `err_o` holds its value until the next accepted start. A start pulse while busy is ignored.
- R12: After reset, `busy_o`, `done_o`, `err_o` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| start_addr_i | input | ADDR_W | First byte address of the range |
| length_i | input | ADDR_W+1 | Range length in bytes |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Result code (0 ok, 1 argument, 2 window, 3 erase timer, 4 device failure, 5 not taken, 6 poll timeout) |
| fl_wr_o | output | 1 | Flash write strobe |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data, sampled on the completing edge |
| fl_rdy_i | input | 1 | Access completes on an edge where this is high |

## Verification
The checker watches the bus handshake on every cycle: held strobes keep their address and data, the done pulse lines up with busy falling, no strobe is driven while idle, and the result code stays stable between operations. Only the bench scenarios can show the correct command order and sector addresses, the argument rules and their boundary, the status classification (erase timer, device failure, not taken, poll limit), window expiry caused by a bus stall, the reset write after an abort, and that a start pulse is ignored while busy.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_ARG     = 3'd1,
        ERR_WINDOW  = 3'd2,
        ERR_TIMER   = 3'd3,
        ERR_DEVICE  = 3'd4,
        ERR_NOTAKE  = 3'd5,
        ERR_POLL_TO = 3'd6
    } erase_err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_SECT,
        S_TMR_RD,
        S_TMR_CHK,
        S_POLL_RD,
        S_POLL_CHK,
        S_ABORT,
        S_FINISH
    } erase_state_e;

    localparam logic [7:0]  CMD_RESET  = 8'hF0;
    localparam logic [7:0]  CMD_SECTOR = 8'h30;
    localparam logic [11:0] UNLOCK_A   = 12'h555;
    localparam logic [11:0] UNLOCK_B   = 12'h2AA;
    localparam int          SETUP_LEN  = 6;

    // Unlock step table: {address, data}.
    function automatic logic [19:0] setup_word(input logic [2:0] idx);
        case (idx)
            3'd0:    return {UNLOCK_A, CMD_RESET};
            3'd1:    return {UNLOCK_A, 8'hAA};
            3'd2:    return {UNLOCK_B, 8'h55};
            3'd3:    return {UNLOCK_A, 8'h80};
            3'd4:    return {UNLOCK_A, 8'hAA};
            default: return {UNLOCK_B, 8'h55};
        endcase
    endfunction

endpackage

// File: rtl/erase_arg_check.sv
module erase_arg_check #(
    parameter int ADDR_W      = 12,
    parameter int SECT_LOG2   = 8,
    parameter int DEV_SECTORS = 16,
    localparam int CNT_W      = ADDR_W + 1 - SECT_LOG2
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W:0]   length,
    output logic              valid,
    output logic [CNT_W-1:0]  nsect
);
    localparam logic [ADDR_W+1:0] DEV_BYTES = (ADDR_W+2)'(DEV_SECTORS) << SECT_LOG2;

    logic [ADDR_W+1:0] end_addr;

    always_comb begin
        end_addr = {2'b00, start_addr} + {1'b0, length};
        valid    = (length != '0)
                && (start_addr[SECT_LOG2-1:0] == '0)
                && (length[SECT_LOG2-1:0] == '0)
                && (end_addr <= DEV_BYTES);
        nsect    = length[ADDR_W:SECT_LOG2];
    end
endmodule

// File: rtl/erase_gap_timer.sv
module erase_gap_timer #(
    parameter int WINDOW_CYC = 64,
    localparam int CW        = $clog2(WINDOW_CYC + 1) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    output logic expired
);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW_CYC);

    logic          armed_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (disarm) begin
            armed_q <= 1'b0;
        end else if (armed_q && cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = armed_q && (cnt_q == LIMIT);
endmodule

// File: rtl/erase_status_eval.sv
module erase_status_eval (
    input  logic [7:0] cur_st,
    input  logic [7:0] prev_st,
    input  logic       have_prev,
    output logic       complete,
    output logic       stuck,
    output logic       dev_fail
);
    always_comb begin
        complete = cur_st[7];
        stuck    = have_prev && !cur_st[7] && (cur_st == prev_st);
        dev_fail = stuck && prev_st[5];
    end
endmodule

// File: rtl/nor_sector_eraser.sv
module nor_sector_eraser
    import nor_erase_pkg::*;
#(
    parameter int SECT_LOG2   = 8,
    parameter int DEV_SECTORS = 16,
    parameter int WINDOW_CYC  = 64,
    parameter int POLL_LIMIT  = 4096,
    localparam int SPAN_W     = $clog2(DEV_SECTORS) + SECT_LOG2,
    localparam int ADDR_W     = (SPAN_W > 12) ? SPAN_W : 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W:0]   length_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [2:0]        err_o,
    output logic              fl_wr_o,
    output logic              fl_rd_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_wdata_o,
    input  logic [7:0]        fl_rdata_i,
    input  logic              fl_rdy_i
);
    localparam int CNT_W = ADDR_W + 1 - SECT_LOG2;
    localparam int PCW   = $clog2(POLL_LIMIT + 1) + 1;
    localparam logic [ADDR_W-1:0] SECT_BYTES = ADDR_W'(1) << SECT_LOG2;

    erase_state_e      state_q, state_d;
    erase_err_e        err_q, err_d;
    logic              set_err;
    logic              adv;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic              first_q, last_q;
    logic [2:0]        step_q;
    logic [7:0]        cur_st_q, prev_st_q;
    logic              have_prev_q, poll_seen_q;

    logic              arg_ok;
    logic [CNT_W-1:0]  arg_nsect;
    logic              win_exp, tmr_arm, tmr_disarm;
    logic              st_complete, st_stuck, st_dev_fail;
    logic              poll_exp;
    logic [19:0]       sw;

    erase_arg_check #(
        .ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2), .DEV_SECTORS(DEV_SECTORS)
    ) u_arg (
        .start_addr(start_addr_i), .length(length_i),
        .valid(arg_ok), .nsect(arg_nsect)
    );

    erase_gap_timer #(.WINDOW_CYC(WINDOW_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .arm(tmr_arm), .disarm(tmr_disarm),
        .expired(win_exp)
    );

    erase_status_eval u_eval (
        .cur_st(cur_st_q), .prev_st(prev_st_q), .have_prev(have_prev_q),
        .complete(st_complete), .stuck(st_stuck), .dev_fail(st_dev_fail)
    );

    // Optional bound on completion polling.
    generate
        if (POLL_LIMIT > 0) begin : g_poll_lim
            logic [PCW-1:0] pcnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pcnt_q <= '0;
                else if (state_q == S_SETUP)
                    pcnt_q <= '0;
                else if (state_q == S_POLL_RD && fl_rdy_i && pcnt_q != PCW'(POLL_LIMIT))
                    pcnt_q <= pcnt_q + 1'b1;
            end
            assign poll_exp = (pcnt_q >= PCW'(POLL_LIMIT));
        end else begin : g_poll_free
            assign poll_exp = 1'b0;
        end
    endgenerate

    // Gap timer control: restart on each accepted non-final sector command.
    assign tmr_arm    = (state_q == S_SECT) && fl_rdy_i && !win_exp && (left_q != '0);
    assign tmr_disarm = (state_q == S_ABORT) || (state_q == S_FINISH)
                     || ((state_q == S_SECT) && fl_rdy_i && (left_q == '0));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state, result code and sector advance.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        set_err = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    set_err = 1'b1;
                    if (arg_ok) begin
                        err_d   = ERR_NONE;
                        state_d = S_SETUP;
                    end else begin
                        err_d   = ERR_ARG;
                        state_d = S_FINISH;
                    end
                end
            end
            S_SETUP: begin
                if (fl_rdy_i && step_q == 3'(SETUP_LEN - 1)) state_d = S_SECT;
            end
            S_SECT: begin
                if (fl_rdy_i) begin
                    if (win_exp) begin
                        set_err = 1'b1;
                        err_d   = ERR_WINDOW;
                        state_d = S_ABORT;
                    end else if (!first_q) begin
                        state_d = S_TMR_RD;
                    end else if (left_q == '0) begin
                        state_d = S_POLL_RD;
                    end else begin
                        state_d = S_SECT;
                        adv     = 1'b1;
                    end
                end
            end
            S_TMR_RD: begin
                if (fl_rdy_i) state_d = S_TMR_CHK;
            end
            S_TMR_CHK: begin
                if (win_exp) begin
                    set_err = 1'b1;
                    err_d   = ERR_WINDOW;
                    state_d = S_ABORT;
                end else if (cur_st_q[3]) begin
                    set_err = 1'b1;
                    err_d   = ERR_TIMER;
                    state_d = S_ABORT;
                end else if (last_q) begin
                    state_d = S_POLL_RD;
                end else begin
                    state_d = S_SECT;
                    adv     = 1'b1;
                end
            end
            S_POLL_RD: begin
                if (fl_rdy_i) state_d = S_POLL_CHK;
            end
            S_POLL_CHK: begin
                if (st_complete) begin
                    state_d = S_FINISH;
                end else if (st_stuck) begin
                    set_err = 1'b1;
                    err_d   = st_dev_fail ? ERR_DEVICE : ERR_NOTAKE;
                    state_d = S_ABORT;
                end else if (poll_exp) begin
                    set_err = 1'b1;
                    err_d   = ERR_POLL_TO;
                    state_d = S_ABORT;
                end else begin
                    state_d = S_POLL_RD;
                end
            end
            S_ABORT: begin
                if (fl_rdy_i) state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q       <= ERR_NONE;
            addr_q      <= '0;
            left_q      <= '0;
            first_q     <= 1'b0;
            last_q      <= 1'b0;
            step_q      <= '0;
            cur_st_q    <= '0;
            prev_st_q   <= '0;
            have_prev_q <= 1'b0;
            poll_seen_q <= 1'b0;
        end else begin
            if (set_err) err_q <= err_d;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        addr_q      <= start_addr_i;
                        left_q      <= arg_nsect - 1'b1;
                        first_q     <= 1'b1;
                        last_q      <= 1'b0;
                        step_q      <= '0;
                        have_prev_q <= 1'b0;
                        poll_seen_q <= 1'b0;
                    end
                end
                S_SETUP: if (fl_rdy_i) step_q <= step_q + 1'b1;
                S_SECT: begin
                    if (fl_rdy_i) begin
                        first_q <= 1'b0;
                        last_q  <= (left_q == '0);
                    end
                end
                S_TMR_RD: if (fl_rdy_i) cur_st_q <= fl_rdata_i;
                S_POLL_RD: begin
                    if (fl_rdy_i) begin
                        prev_st_q   <= cur_st_q;
                        cur_st_q    <= fl_rdata_i;
                        have_prev_q <= poll_seen_q;
                        poll_seen_q <= 1'b1;
                    end
                end
                default: ;
            endcase
            if (adv) begin
                addr_q <= addr_q + SECT_BYTES;
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign sw = setup_word(step_q);

    // Outputs.
    always_comb begin
        busy_o     = (state_q != S_IDLE) && (state_q != S_FINISH);
        done_o     = (state_q == S_FINISH);
        err_o      = err_q;
        fl_wr_o    = 1'b0;
        fl_rd_o    = 1'b0;
        fl_addr_o  = addr_q;
        fl_wdata_o = '0;
        unique case (state_q)
            S_SETUP: begin
                fl_wr_o    = 1'b1;
                fl_addr_o  = ADDR_W'(sw[19:8]);
                fl_wdata_o = sw[7:0];
            end
            S_SECT: begin
                fl_wr_o    = 1'b1;
                fl_wdata_o = CMD_SECTOR;
            end
            S_TMR_RD, S_POLL_RD: fl_rd_o = 1'b1;
            S_ABORT: begin
                fl_wr_o    = 1'b1;
                fl_addr_o  = ADDR_W'(UNLOCK_A);
                fl_wdata_o = CMD_RESET;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nor_sector_eraser_checks.sv
module nor_sector_eraser_checks #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [2:0]    err,
    input logic          fl_wr,
    input logic          fl_rd,
    input logic          fl_rdy,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_wdata
);
    // R9: a pending write keeps strobe, address and data.
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr && !fl_rdy |=> fl_wr && $stable(fl_addr) && $stable(fl_wdata));

    // R9: a pending read keeps strobe and address.
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd && !fl_rdy |=> fl_rd && $stable(fl_addr));

    // R11: completion is a single-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: busy only drops together with done.
    p_busy_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R1: no bus traffic unless an erase is running.
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_wr && !fl_rd);

    // R11: result code is held between operations.
    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !done |=> busy || done || $stable(err));
endmodule

bind nor_sector_eraser nor_sector_eraser_checks #(.AW(ADDR_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o), .err(err_o),
    .fl_wr(fl_wr_o), .fl_rd(fl_rd_o), .fl_rdy(fl_rdy_i),
    .fl_addr(fl_addr_o), .fl_wdata(fl_wdata_o)
);

// File: tb/nor_sector_eraser_test.sv
`timescale 1ns/1ps
module nor_sector_eraser_test;

    localparam int AW = 12;
    localparam int SECT = 256;
    localparam int NVEC = 12;

    // Result codes as stated in the requirements.
    localparam int C_OK = 0, C_ARG = 1, C_WIN = 2, C_TMR = 3,
                   C_DEV = 4, C_NOT = 5, C_PTO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [AW:0]   length_i = '0;
    logic          busy_o, done_o, fl_wr_o, fl_rd_o;
    logic [2:0]    err_o;
    logic [AW-1:0] fl_addr_o;
    logic [7:0]    fl_wdata_o, fl_rdata_i;
    logic          fl_rdy_i;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    nor_sector_eraser #(
        .SECT_LOG2(8), .DEV_SECTORS(16), .WINDOW_CYC(20), .POLL_LIMIT(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .start_addr_i(start_addr_i), .length_i(length_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .fl_wr_o(fl_wr_o), .fl_rd_o(fl_rd_o), .fl_addr_o(fl_addr_o),
        .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata_i), .fl_rdy_i(fl_rdy_i)
    );

    // Flash model: logs accepted writes, scripts status reads, can stall one read.
    logic [AW-1:0] log_addr [64];
    logic [7:0]    log_data [64];
    int  wr_n = 0, rd_idx = 0;
    logic clr = 1'b0;
    int  script = 0, nsect = 1;
    int  stall_idx = -1, stall_left = 0;

    function automatic logic [7:0] stat_fn(input int scr, input int idx, input int ns);
        int t;
        int p;
        t = ns - 1;
        if (idx < t) return (scr == 1) ? 8'h08 : 8'h00;
        p = idx - t;
        case (scr)
            0:       return (p < 2) ? ((p % 2 == 1) ? 8'h40 : 8'h00) : 8'h80;
            2:       return 8'h20;
            3:       return 8'h00;
            default: return (p % 2 == 1) ? 8'h40 : 8'h00;
        endcase
    endfunction

    assign fl_rdata_i = stat_fn(script, rd_idx, nsect);
    assign fl_rdy_i   = !(fl_rd_o && rd_idx == stall_idx && stall_left > 0);

    always @(posedge clk) begin
        if (clr) begin
            wr_n   <= 0;
            rd_idx <= 0;
        end else begin
            if (fl_wr_o && fl_rdy_i) begin
                if (wr_n < 64) begin
                    log_addr[wr_n] <= fl_addr_o;
                    log_data[wr_n] <= fl_wdata_o;
                end
                wr_n <= wr_n + 1;
            end
            if (fl_rd_o && fl_rdy_i) rd_idx <= rd_idx + 1;
            if (fl_rd_o && rd_idx == stall_idx && stall_left > 0)
                stall_left <= stall_left - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // Launch one erase and wait for done; returns the code seen with done.
    task automatic run_op(input logic [AW-1:0] sa, input logic [AW:0] ln,
                          input int scr, output int code);
        int w;
        @(negedge clk);
        clr = 1'b1;
        script = scr;
        nsect = (ln >= SECT) ? int'(ln) / SECT : 1;
        @(negedge clk);
        clr = 1'b0;
        start_addr_i = sa;
        length_i = ln;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        w = 0;
        while (!done_o && w < 3000) begin
            @(negedge clk);
            w++;
        end
        code = int'(err_o);
        chk(done_o == 1'b1, "R11", "done seen", int'(done_o), 1);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R11", "done one cycle", int'(done_o), 0);
    endtask

    // Compare the write log with the expected unlock, sector and reset writes.
    task automatic check_seq(input logic [AW-1:0] sa, input int nwr, input int code);
        logic [11:0] ea [6] = '{12'h555, 12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA};
        logic [7:0]  ed [6] = '{8'hF0, 8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
        bit ok;
        int ncmd;
        ok = 1'b1;
        if (nwr > 0) begin
            ncmd = nwr - 6 - ((code != C_OK) ? 1 : 0);
            for (int i = 0; i < 6; i++)
                if (log_addr[i] != ea[i] || log_data[i] != ed[i]) ok = 1'b0;
            chk(ok, "R2", "unlock sequence", int'(log_data[0]), 8'hF0);
            ok = 1'b1;
            for (int i = 0; i < ncmd; i++)
                if (log_addr[6+i] != sa + AW'(i * SECT) || log_data[6+i] != 8'h30) ok = 1'b0;
            chk(ok, "R3", "sector commands", int'(log_addr[6]), int'(sa));
            if (code != C_OK)
                chk(log_addr[nwr-1] == 12'h555 && log_data[nwr-1] == 8'hF0, "R10",
                    "reset write after abort", int'(log_data[nwr-1]), 8'hF0);
        end
    endtask

    // {start[11:0], length[12:0], script[2:0], code[2:0], writes[7:0]}
    localparam logic [38:0] VEC [NVEC] = '{
        {12'h000, 13'h0100, 3'd0, 3'd0, 8'd7},   // R6 single sector
        {12'h300, 13'h0300, 3'd0, 3'd0, 8'd9},   // R6 three sectors
        {12'hF00, 13'h0100, 3'd0, 3'd0, 8'd7},   // R1 ends at last byte
        {12'h000, 13'h1000, 3'd0, 3'd0, 8'd22},  // R3 whole device
        {12'h100, 13'h0000, 3'd0, 3'd1, 8'd0},   // R1 zero length
        {12'h180, 13'h0100, 3'd0, 3'd1, 8'd0},   // R1 misaligned start
        {12'h200, 13'h0080, 3'd0, 3'd1, 8'd0},   // R1 misaligned length
        {12'hF00, 13'h0200, 3'd0, 3'd1, 8'd0},   // R1 past the end
        {12'h400, 13'h0200, 3'd1, 3'd3, 8'd9},   // R4 erase timer bit
        {12'h000, 13'h0100, 3'd2, 3'd4, 8'd8},   // R7 device failure
        {12'h500, 13'h0200, 3'd3, 3'd5, 8'd9},   // R7 not taken
        {12'h000, 13'h0100, 3'd4, 3'd6, 8'd8}    // R8 poll limit
    };

    initial begin
        int code;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(busy_o == 0 && done_o == 0 && err_o == 0 && fl_wr_o == 0 && fl_rd_o == 0,
            "R12", "reset outputs", int'({busy_o, done_o, err_o, fl_wr_o, fl_rd_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic [38:0] e;
            e = VEC[v];
            run_op(e[38:27], e[26:14], int'(e[13:11]), code);
            chk(code == int'(e[10:8]), (e[10:8] == 3'd1) ? "R1" :
                (e[10:8] == 3'd0) ? "R6" : (e[10:8] == 3'd3) ? "R4" :
                (e[10:8] == 3'd6) ? "R8" : "R7", "result code", code, int'(e[10:8]));
            chk(wr_n == int'(e[7:0]), "R3", "write count", wr_n, int'(e[7:0]));
            check_seq(e[38:27], wr_n, code);
        end

        // R11 code held after an argument error
        run_op(12'h010, 13'h0100, 0, code);
        repeat (5) @(negedge clk);
        chk(err_o == 3'd1, "R11", "code held while idle", int'(err_o), C_ARG);

        // R9 short read stall still succeeds
        stall_idx = 0; stall_left = 5;
        run_op(12'h200, 13'h0300, 0, code);
        chk(code == C_OK && wr_n == 9, "R9", "stalled read result", code, C_OK);
        check_seq(12'h200, wr_n, code);

        // R5 long stall closes the acceptance window
        stall_idx = 0; stall_left = 30;
        run_op(12'h200, 13'h0300, 0, code);
        chk(code == C_WIN, "R5", "window code", code, C_WIN);
        chk(wr_n == 9, "R5", "writes before abort", wr_n, 9);
        check_seq(12'h200, wr_n, code);
        stall_idx = -1; stall_left = 0;

        // R11 start ignored while busy
        @(negedge clk);
        clr = 1'b1; script = 0; nsect = 3;
        @(negedge clk);
        clr = 1'b0;
        start_addr_i = 12'h600; length_i = 13'h0300; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        start_addr_i = 12'hF00; length_i = 13'h0000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int w = 0; w < 3000 && !done_o; w++) @(negedge clk);
        chk(err_o == 3'd0, "R11", "busy start ignored code", int'(err_o), C_OK);
        chk(wr_n == 9, "R11", "busy start ignored writes", wr_n, 9);
        check_seq(12'h600, wr_n, C_OK);
        repeat (2) @(negedge clk);

        finish_run();
    end
endmodule